// File: doc/BRIEF.md
# Latched Phase-Coded Display Driver for a Three-and-a-Half Digit LCD

This block turns a signed decimal reading into the drive lines of a static three-and-a-half digit liquid-crystal panel. The reading is presented as a sign bit, a leading-one bit and three BCD digits. A one-cycle conversion-done strobe captures the reading into a display latch. A hold input freezes the latch so that the panel keeps showing the last captured value while new readings keep arriving.

The panel needs alternating drive, so the block produces a square-wave backplane by dividing the system clock. Every segment line copies the backplane when its segment is dark and carries the inverted backplane when its segment is lit. The panel therefore never sees a steady voltage across a segment during normal display.

A test input lights every segment, the leading one and the minus sign, so that the panel shows -1888. The latch is left untouched while test is high. The hold input must be tied low, or driven low, wherever continuous updating is wanted.

Top module: `lcd_drv_top`

## Requirements
- R1: After reset `bpOut` is low. It then toggles every BP_DIV/2 clock cycles, which gives a square wave with a period of BP_DIV clocks (800 by default).
- R2: Every segment line, including `thouSeg` and `minusSeg`, equals `bpOut` when its segment is dark and equals the inverse of `bpOut` when its segment is lit. A line changes on the same clock edge as `bpOut`.
- R3: Each digit field is a 7-bit vector with bit 0 = top, 1 = upper right, 2 = lower right, 3 = bottom, 4 = lower left, 5 = upper left, 6 = middle. The lit patterns for BCD 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. Codes 10 to 15 light nothing.
- R4: When `readyStb` is high at a clock edge while `holdIn` is low, the latch captures the reading. The new lit pattern appears on the outputs right after that edge.
- R5: When `holdIn` is high, a `readyStb` pulse is ignored and the display keeps its previous contents. The next strobe that arrives with `holdIn` low loads normally.
- R6: Changes on the reading inputs have no effect on the display unless a loading strobe occurs.
- R7: While `testIn` is high, every segment line, `thouSeg` and `minusSeg` are lit (each is the inverse of `bpOut`). When `testIn` returns low, the latched display reappears unchanged.
- R8: `minusSeg` is lit exactly when the latched sign bit is 1. This includes a negative reading of zero.
- R9: The single `thouSeg` line is lit exactly when the latched leading-one bit is 1.
- R10: While `rstN` is low, `bpOut` is low and the latch is cleared, so every segment is dark and every line reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| readyStb | input | 1 | Conversion-done strobe, one cycle |
| holdIn | input | 1 | Freeze display latch when high; tie low for continuous update |
| testIn | input | 1 | Light all segments when high |
| negIn | input | 1 | Sign of reading, 1 = negative |
| thouIn | input | 1 | Leading-one digit |
| hundIn | input | 4 | Hundreds BCD digit |
| tensIn | input | 4 | Tens BCD digit |
| unitsIn | input | 4 | Units BCD digit |
| bpOut | output | 1 | Backplane square wave |
| hundSeg | output | 7 | Hundreds segment lines |
| tensSeg | output | 7 | Tens segment lines |
| unitsSeg | output | 7 | Units segment lines |
| thouSeg | output | 1 | Leading-one line (both halves) |
| minusSeg | output | 1 | Minus sign line |

## Verification
The bound checker watches on every cycle:
- the backplane toggle spacing, using its own counter;
- the forced-lit state under test;
- that the lit pattern stays put whenever no loading strobe occurs or hold is high;
- that the sign and leading-one lines follow the captured inputs after a load.

Only the bench scenarios can show that the decoded patterns are correct for every digit in every position. The same goes for the blanking of non-BCD codes and for the display coming back intact after test or hold.

// File: rtl/lcd_drv_pkg.sv
`timescale 1ns/1ps
package lcd_drv_pkg;
  localparam int SEG_W = 7;
  localparam int DIG_W = 4;
  localparam int NDIG  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // capture reading this edge
    logic bpLevel;  // current backplane level
  } ctrlStb_t;

  // lit pattern for one BCD digit; bit0 top, going clockwise, bit6 middle
  function automatic logic [SEG_W-1:0] segDecode(input logic [DIG_W-1:0] bcd);
    logic [SEG_W-1:0] pat;
    unique case (bcd)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = '0;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/lcd_drv_ctrl.sv
`timescale 1ns/1ps
module lcd_drv_ctrl
  import lcd_drv_pkg::*;
#(
  parameter int BP_DIV = 800
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     readyStb,
  input  logic     holdIn,
  output ctrlStb_t stb
);
  localparam int HALF  = BP_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] divCnt;
  logic             bpReg;
  logic             wrapNow;

  assign wrapNow = (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bpReg  <= 1'b0;
    end else if (wrapNow) begin
      divCnt <= '0;
      bpReg  <= ~bpReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    stb.loadEn  = readyStb & ~holdIn;
    stb.bpLevel = bpReg;
  end
endmodule

// File: rtl/lcd_drv_datapath.sv
`timescale 1ns/1ps
module lcd_drv_datapath
  import lcd_drv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStb_t              stb,
  input  logic                  testIn,
  input  logic                  negIn,
  input  logic                  thouIn,
  input  logic [NDIG*DIG_W-1:0] digitsIn,
  output logic [NDIG*SEG_W-1:0] segOut,
  output logic                  thouOut,
  output logic                  minusOut,
  output logic                  bpOut
);
  logic thouLat, negLat;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    logic [SEG_W-1:0] patNext, patLat;
    assign patNext = segDecode(digitsIn[g*DIG_W +: DIG_W]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           patLat <= '0;
      else if (stb.loadEn) patLat <= patNext;
    end

    assign segOut[g*SEG_W +: SEG_W] = (patLat | {SEG_W{testIn}}) ^ {SEG_W{stb.bpLevel}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thouLat <= 1'b0;
      negLat  <= 1'b0;
    end else if (stb.loadEn) begin
      thouLat <= thouIn;
      negLat  <= negIn;
    end
  end

  assign thouOut  = (thouLat | testIn) ^ stb.bpLevel;
  assign minusOut = (negLat  | testIn) ^ stb.bpLevel;
  assign bpOut    = stb.bpLevel;
endmodule

// File: rtl/lcd_drv_top.sv
`timescale 1ns/1ps
module lcd_drv_top
  import lcd_drv_pkg::*;
#(
  parameter int BP_DIV = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       readyStb,
  input  logic       holdIn,
  input  logic       testIn,
  input  logic       negIn,
  input  logic       thouIn,
  input  logic [3:0] hundIn,
  input  logic [3:0] tensIn,
  input  logic [3:0] unitsIn,
  output logic       bpOut,
  output logic [6:0] hundSeg,
  output logic [6:0] tensSeg,
  output logic [6:0] unitsSeg,
  output logic       thouSeg,
  output logic       minusSeg
);
  ctrlStb_t              stb;
  logic [NDIG*SEG_W-1:0] segBus;

  lcd_drv_ctrl #(.BP_DIV(BP_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .readyStb(readyStb), .holdIn(holdIn), .stb(stb)
  );

  lcd_drv_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .testIn(testIn),
    .negIn(negIn), .thouIn(thouIn),
    .digitsIn({hundIn, tensIn, unitsIn}),
    .segOut(segBus), .thouOut(thouSeg), .minusOut(minusSeg), .bpOut(bpOut)
  );

  assign unitsSeg = segBus[0*SEG_W +: SEG_W];
  assign tensSeg  = segBus[1*SEG_W +: SEG_W];
  assign hundSeg  = segBus[2*SEG_W +: SEG_W];
endmodule

// File: rtl/lcd_drv_chk.sv
`timescale 1ns/1ps
module lcd_drv_chk #(
  parameter int BP_DIV = 800
) (
  input logic       clk,
  input logic       rstN,
  input logic       readyStb,
  input logic       holdIn,
  input logic       testIn,
  input logic       negIn,
  input logic       thouIn,
  input logic       bpOut,
  input logic [6:0] hundSeg,
  input logic [6:0] tensSeg,
  input logic [6:0] unitsSeg,
  input logic       thouSeg,
  input logic       minusSeg
);
  localparam int HALF  = BP_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] refCnt;
  logic [22:0]      litBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                refCnt <= '0;
    else if (refCnt == LAST)  refCnt <= '0;
    else                      refCnt <= refCnt + 1'b1;
  end

  assign litBits = {hundSeg, tensSeg, unitsSeg, thouSeg, minusSeg} ^ {23{bpOut}};

  // R1
  bp_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refCnt == LAST) |=> (bpOut != $past(bpOut)));
  // R1
  bp_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refCnt != LAST) |=> $stable(bpOut));
  // R10
  reset_dark_chk: assert property (@(posedge clk)
    !rstN |-> (!bpOut && litBits == '0));
  // R7
  test_all_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    testIn |-> (litBits == '1));
  // R5
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdIn && !testIn) |=> (testIn || litBits == $past(litBits)));
  // R6
  no_strobe_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyStb && !testIn) |=> (testIn || litBits == $past(litBits)));
  // R8
  sign_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyStb && !holdIn) |=> (testIn || litBits[0] == $past(negIn)));
  // R9
  thou_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyStb && !holdIn) |=> (testIn || litBits[1] == $past(thouIn)));
endmodule

bind lcd_drv_top lcd_drv_chk #(.BP_DIV(BP_DIV)) chk_i (
  .clk(clk), .rstN(rstN), .readyStb(readyStb), .holdIn(holdIn), .testIn(testIn),
  .negIn(negIn), .thouIn(thouIn), .bpOut(bpOut), .hundSeg(hundSeg),
  .tensSeg(tensSeg), .unitsSeg(unitsSeg), .thouSeg(thouSeg), .minusSeg(minusSeg)
);

// File: tb/lcd_drv_top_tb_top.sv
`timescale 1ns/1ps
module lcd_drv_top_tb_top;
  localparam int BP_DIV = 800;
  localparam int NVEC   = 12;
  // vector: bit13 sign, bit12 leading one, then hundreds, tens, units BCD
  localparam logic [13:0] VEC [NVEC] = '{
    14'h0000, 14'h0123, 14'h0456, 14'h0789, 14'h1999, 14'h2000,
    14'h3345, 14'h0912, 14'h2678, 14'h1234, 14'h0567, 14'h0888
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic readyStb = 0, holdIn = 0, testIn = 0, negIn = 0, thouIn = 0;
  logic [3:0] hundIn = 0, tensIn = 0, unitsIn = 0;
  logic bpOut, thouSeg, minusSeg;
  logic [6:0] hundSeg, tensSeg, unitsSeg;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_drv_top #(.BP_DIV(BP_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .readyStb(readyStb), .holdIn(holdIn), .testIn(testIn),
    .negIn(negIn), .thouIn(thouIn), .hundIn(hundIn), .tensIn(tensIn), .unitsIn(unitsIn),
    .bpOut(bpOut), .hundSeg(hundSeg), .tensSeg(tensSeg), .unitsSeg(unitsSeg),
    .thouSeg(thouSeg), .minusSeg(minusSeg)
  );

  function automatic logic [6:0] expPat(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [22:0] expLit(input logic [13:0] v);
    return {expPat(v[11:8]), expPat(v[7:4]), expPat(v[3:0]), v[12], v[13]};
  endfunction

  function automatic logic [22:0] litNow();
    return {hundSeg, tensSeg, unitsSeg, thouSeg, minusSeg} ^ {23{bpOut}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic [13:0] v, input bit strobe);
    @(negedge clk);
    {negIn, thouIn, hundIn, tensIn, unitsIn} = v;
    readyStb = strobe;
    @(negedge clk);
    readyStb = 0;
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    realtime tRise, tFall;
    logic [22:0] a;
    // R10 reset state
    repeat (3) @(negedge clk);
    a = {hundSeg, tensSeg, unitsSeg, thouSeg, minusSeg};
    check(a == '0 && !bpOut, "R10", a, '0);
    rstN = 1;

    // R3 R4 R8 R9 vector walk
    foreach (VEC[i]) begin
      present(VEC[i], 1'b1);
      a = litNow();
      check(a == expLit(VEC[i]), "R3/R4 vector", a, expLit(VEC[i]));
    end

    // R3 non-BCD codes blank
    present(14'h0AFC, 1'b1);
    a = litNow();
    check(a == '0, "R3 non-BCD blank", a, '0);

    // R6 no strobe: inputs ignored
    present(14'h0321, 1'b1);
    present(14'h3777, 1'b0);
    a = litNow();
    check(a == expLit(14'h0321), "R6", a, expLit(14'h0321));

    // R5 hold blocks strobe, then resumes
    @(negedge clk) holdIn = 1;
    present(14'h1555, 1'b1);
    a = litNow();
    check(a == expLit(14'h0321), "R5 held", a, expLit(14'h0321));
    @(negedge clk) holdIn = 0;
    present(14'h1555, 1'b1);
    a = litNow();
    check(a == expLit(14'h1555), "R5 resumed", a, expLit(14'h1555));

    // R7 test forces all lit, latch kept
    @(negedge clk) testIn = 1;
    #1 a = litNow();
    check(a == '1, "R7 test on", a, '1);
    @(negedge clk) testIn = 0;
    #1 a = litNow();
    check(a == expLit(14'h1555), "R7 test off", a, expLit(14'h1555));

    // R1 backplane period
    @(posedge bpOut) tRise = $realtime;
    @(negedge bpOut) tFall = $realtime;
    check((tFall - tRise) == 400.0 * 20.0, "R1 half period", 23'(int'(tFall - tRise)), 23'(8000));

    // R2 raw phase: units=1 lit b,c only, at both backplane levels
    present(14'h0001, 1'b1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(unitsSeg == ({7{bpOut}} ^ 7'h06) && minusSeg == bpOut && thouSeg == bpOut,
            "R2 phase", {16'h0, unitsSeg}, {16'h0, {7{bpOut}} ^ 7'h06});
      @(posedge bpOut or negedge bpOut);
    end

    done = 1;
    finish();
  end
endmodule